// File: doc/BRIEF.md
# SDRAM Bank Timing Guard

This block sits beside the command bus of a four-bank synchronous DRAM and only observes it. On every clock edge it decodes the command from the three active-low strobes, the two-bit bank select and the auto-precharge address bit. It keeps one small state machine per bank with the states BK_IDLE, BK_OPEN and BK_STALE. It also keeps a saturating age counter per bank that counts cycles since that bank's last accepted activate, plus one shared counter that counts cycles since the last accepted activate to any bank.

Each command is judged against the bank state and the spacing limits. The limits are parameters in clock cycles: row-to-column delay, activate-to-activate in one bank, activate-to-activate across banks, minimum active time and maximum active time. When a rule is broken, the block raises a one-cycle pulse in the cycle after the offending edge. With the pulse it gives a 3-bit rule code and the bank involved. It is meant for simulation or silicon debug alongside a memory controller. It does not handle refresh, mode settings or data.

The bank transitions are named as follows:
- IDLE to OPEN on an activate.
- OPEN to IDLE on a single-bank precharge or a precharge-all.
- OPEN to STALE when the bank has stayed open past the maximum active time.
- STALE to IDLE on any precharge.

Top module: `sdram_bank_guard`

## Requirements
- R1: While `rst_n` is low and after its release, every bank is idle, the per-bank timers read as long expired, and `viol_pulse`, `viol_code` and `viol_bank` are all zero.
- R2: Command encoding, with the strobe levels written as {ras_n,cas_n,we_n}:
  - 011 is activate of bank `ba`.
  - 010 with `a10`=0 precharges bank `ba`; 010 with `a10`=1 precharges every bank and ignores `ba`.
  - 101 with `a10`=0 is a read of bank `ba`; 100 with `a10`=0 is a write of bank `ba`.
  - An activate to an idle bank opens that bank.
- R3: An activate to a bank that is open or stale raises code 1 and leaves the bank and its timer unchanged.
- R4: An activate to an idle bank fewer than TRC cycles after that bank's previous activate raises code 2. The bank still opens. Exactly TRC cycles is legal.
- R5: An activate to an idle bank fewer than TRRD cycles after the last accepted activate to any bank raises code 3. The bank still opens.
- R6: A single-bank precharge to an open bank fewer than TRAS_MIN cycles after its activate raises code 4. Any single-bank precharge returns the bank to idle, and a precharge of an idle bank is legal.
- R7: A precharge-all is legal whatever the bank states are, and leaves every bank idle.
- R8: A read or write to an idle bank raises code 5.
- R9: A read or write to an open bank fewer than TRCD cycles after its activate raises code 6.
- R10: A bank still open exactly TRAS_MAX+1 cycles after its activate raises code 7 with that bank once. No later cycle repeats it for the same activation.
- R11: Only one rule is reported per cycle, in this order:
  - A command rule outranks an over-age report.
  - For an activate, the open-bank rule outranks the TRC rule, which outranks the TRRD rule.
- R12: The pulse, code and bank appear in the cycle after the edge that sampled the command. When no rule is broken, all three are zero.
- R13: All other encodings have no effect on bank state and raise nothing. This covers refresh-like 001, nop 111, and read or write with `a10`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge samples the command |
| rst_n | input | 1 | Active-low synchronous reset, all banks idle |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Precharge-all / auto-precharge address bit |
| viol_pulse | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Broken rule: 1 open, 2 TRC, 3 TRRD, 4 TRAS_MIN, 5 idle access, 6 TRCD, 7 over-age |
| viol_bank | output | 2 | Bank involved in the violation |

## Verification
A bank state machine left in the wrong state shows on the next command to that bank:
- A wrongly open bank turns a legal activate into code 1.
- A wrongly idle bank turns a legal read into code 5.

Either shows one cycle after the command edge. An age counter that is off by one moves the boundary cycles for TRC, TRCD and TRAS_MIN, and moves the single over-age pulse, by that cycle. The bench therefore drives commands exactly at and one short of each limit. It compares all three outputs against a cycle-counting model on every clock.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_PRE_ONE,
        CMD_PRE_ALL,
        CMD_RD,
        CMD_WR,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_STALE
    } bank_st_e;

    typedef enum logic [2:0] {
        VC_NONE      = 3'd0,
        VC_ACT_OPEN  = 3'd1,
        VC_ACT_TRC   = 3'd2,
        VC_ACT_TRRD  = 3'd3,
        VC_PRE_EARLY = 3'd4,
        VC_RW_IDLE   = 3'd5,
        VC_RW_TRCD   = 3'd6,
        VC_OVERDUE   = 3'd7
    } viol_e;

endpackage

// File: rtl/sbg_cmd_decode.sv
module sbg_cmd_decode
    import sbg_pkg::*;
(
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);

    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = a10 ? CMD_PRE_ALL : CMD_PRE_ONE;
            3'b101:  cmd = a10 ? CMD_OTHER : CMD_RD;
            3'b100:  cmd = a10 ? CMD_OTHER : CMD_WR;
            3'b111:  cmd = CMD_NOP;
            default: cmd = CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/sbg_bank_fsm.sv
module sbg_bank_fsm
    import sbg_pkg::*;
#(
    parameter int TRAS_MAX = 40,
    parameter int CW       = $clog2(TRAS_MAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_req,
    input  logic          pre_req,
    output bank_st_e      st,
    output logic [CW-1:0] age,
    output logic          expire
);

    // age saturates one past the longest legal open time
    localparam logic [CW-1:0] AGE_CAP = CW'(TRAS_MAX + 1);

    bank_st_e nxt;
    logic     accept;

    assign accept = act_req && (st == BK_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) st <= BK_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            BK_IDLE: begin
                if (act_req) nxt = BK_OPEN;
            end
            BK_OPEN: begin
                if (pre_req)              nxt = BK_IDLE;
                else if (age == AGE_CAP)  nxt = BK_STALE;
            end
            BK_STALE: begin
                if (pre_req) nxt = BK_IDLE;
            end
            default: nxt = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              age <= AGE_CAP;
        else if (accept)         age <= CW'(1);
        else if (age != AGE_CAP) age <= age + CW'(1);
    end

    always_comb begin
        expire = (st == BK_OPEN) && (age == AGE_CAP);
    end

endmodule

// File: rtl/sbg_viol_arb.sv
module sbg_viol_arb
    import sbg_pkg::*;
#(
    parameter int BA_W     = 2,
    parameter int NB       = 4,
    parameter int CW       = 6,
    parameter int GW       = 2,
    parameter int TRCD     = 3,
    parameter int TRC      = 10,
    parameter int TRRD     = 2,
    parameter int TRAS_MIN = 7
) (
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  bank_st_e        st      [NB],
    input  logic [CW-1:0]   age     [NB],
    input  logic [NB-1:0]   expire,
    input  logic [GW-1:0]   gap,
    output viol_e           code,
    output logic [BA_W-1:0] bank
);

    localparam logic [CW-1:0] LIM_RCD = CW'(TRCD);
    localparam logic [CW-1:0] LIM_RC  = CW'(TRC);
    localparam logic [CW-1:0] LIM_RAS = CW'(TRAS_MIN);
    localparam logic [GW-1:0] LIM_RRD = GW'(TRRD);

    bank_st_e      cur_st;
    logic [CW-1:0] cur_age;

    assign cur_st  = st[ba];
    assign cur_age = age[ba];

    always_comb begin
        code = VC_NONE;
        bank = '0;
        unique case (cmd)
            CMD_ACT: begin
                if (cur_st != BK_IDLE)      code = VC_ACT_OPEN;
                else if (cur_age < LIM_RC)  code = VC_ACT_TRC;
                else if (gap < LIM_RRD)     code = VC_ACT_TRRD;
            end
            CMD_PRE_ONE: begin
                if ((cur_st != BK_IDLE) && (cur_age < LIM_RAS)) code = VC_PRE_EARLY;
            end
            CMD_RD, CMD_WR: begin
                if (cur_st == BK_IDLE)      code = VC_RW_IDLE;
                else if (cur_age < LIM_RCD) code = VC_RW_TRCD;
            end
            default: code = VC_NONE;
        endcase
        if (code != VC_NONE) begin
            bank = ba;
        end else begin
            // descending scan so the lowest expiring bank is the one kept
            for (int i = NB - 1; i >= 0; i--) begin
                if (expire[i]) begin
                    code = VC_OVERDUE;
                    bank = BA_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
    import sbg_pkg::*;
#(
    parameter int TRCD     = 3,
    parameter int TRC      = 10,
    parameter int TRRD     = 2,
    parameter int TRAS_MIN = 7,
    parameter int TRAS_MAX = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [1:0] ba,
    input  logic       a10,
    output logic       viol_pulse,
    output logic [2:0] viol_code,
    output logic [1:0] viol_bank
);

    localparam int BA_W = 2;
    localparam int NB   = 1 << BA_W;
    localparam int CW   = $clog2(TRAS_MAX + 2);
    localparam int GW   = $clog2(TRRD + 1);

    cmd_e            cmd;
    bank_st_e        bank_st [NB];
    logic [CW-1:0]   bank_age [NB];
    logic [NB-1:0]   expire;
    logic [GW-1:0]   gap;
    logic            act_ok;
    viol_e           code_d;
    viol_e           code_q;
    logic [BA_W-1:0] bank_d;

    sbg_cmd_decode u_dec (
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic act_hit;
        logic pre_hit;
        assign act_hit = (cmd == CMD_ACT) && (ba == BA_W'(g));
        assign pre_hit = (cmd == CMD_PRE_ALL) ||
                         ((cmd == CMD_PRE_ONE) && (ba == BA_W'(g)));
        sbg_bank_fsm #(
            .TRAS_MAX (TRAS_MAX),
            .CW       (CW)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_req (act_hit),
            .pre_req (pre_hit),
            .st      (bank_st[g]),
            .age     (bank_age[g]),
            .expire  (expire[g])
        );
    end

    assign act_ok = (cmd == CMD_ACT) && (bank_st[ba] == BK_IDLE);

    // cycles since last accepted activate to any bank, saturating at TRRD
    always_ff @(posedge clk) begin
        if (!rst_n)                gap <= GW'(TRRD);
        else if (act_ok)           gap <= GW'(1);
        else if (gap != GW'(TRRD)) gap <= gap + GW'(1);
    end

    sbg_viol_arb #(
        .BA_W     (BA_W),
        .NB       (NB),
        .CW       (CW),
        .GW       (GW),
        .TRCD     (TRCD),
        .TRC      (TRC),
        .TRRD     (TRRD),
        .TRAS_MIN (TRAS_MIN)
    ) u_arb (
        .cmd    (cmd),
        .ba     (ba),
        .st     (bank_st),
        .age    (bank_age),
        .expire (expire),
        .gap    (gap),
        .code   (code_d),
        .bank   (bank_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q     <= VC_NONE;
            viol_bank  <= '0;
            viol_pulse <= 1'b0;
        end else begin
            code_q     <= code_d;
            viol_bank  <= bank_d;
            viol_pulse <= (code_d != VC_NONE);
        end
    end

    assign viol_code = code_q;

endmodule

// File: rtl/sbg_guard_chk.sv
module sbg_guard_chk
    import sbg_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int NB   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input cmd_e            cmd,
    input logic [BA_W-1:0] ba,
    input bank_st_e        st [NB],
    input logic [2:0]      viol_code,
    input logic [BA_W-1:0] viol_bank
);

    logic any_busy;
    always_comb begin
        any_busy = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (st[i] != BK_IDLE) any_busy = 1'b1;
        end
    end

    AST_ACT_OPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && st[ba] != BK_IDLE) |=> viol_code == 3'd1); // R3

    AST_RW_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && st[ba] == BK_IDLE) |=> viol_code == 3'd5); // R8

    AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && st[ba] == BK_IDLE) |=> st[$past(ba)] == BK_OPEN); // R2

    AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE_ALL) |=> !any_busy); // R7

    AST_OVERDUE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_code == 3'd7) |=> !(viol_code == 3'd7 && viol_bank == $past(viol_bank))); // R10

endmodule

bind sdram_bank_guard sbg_guard_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ba        (ba),
    .st        (bank_st),
    .viol_code (viol_code),
    .viol_bank (viol_bank)
);

// File: tb/sdram_bank_guard_tb_top.sv
`timescale 1ns/1ps
module sdram_bank_guard_tb_top;

    localparam int TRCD     = 3;
    localparam int TRC      = 10;
    localparam int TRRD     = 2;
    localparam int TRAS_MIN = 7;
    localparam int TRAS_MAX = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n  = 1'b1;
    logic [1:0] ba    = 2'd0;
    logic       a10   = 1'b0;
    logic       viol_pulse;
    logic [2:0] viol_code;
    logic [1:0] viol_bank;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model: edge numbers of activates, open flags
    int edge_n = 0;
    int last_act [4];
    bit open_b [4];
    int last_any = -1000;

    always #4 clk = ~clk;

    sdram_bank_guard #(
        .TRCD(TRCD), .TRC(TRC), .TRRD(TRRD), .TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .viol_pulse(viol_pulse), .viol_code(viol_code),
        .viol_bank(viol_bank)
    );

    task automatic check_out(input string tag, input int ec, input int eb);
        checks++;
        if (viol_code !== 3'(ec) || viol_bank !== 2'(eb) || viol_pulse !== (ec != 0)) begin
            failures++;
            $display("FAIL %s: code=%0d bank=%0d pulse=%0b expected code=%0d bank=%0d pulse=%0b",
                     tag, viol_code, viol_bank, viol_pulse, ec, eb, (ec != 0));
        end
    endtask

    task automatic step(input logic r, input logic c, input logic w,
                        input logic [1:0] b, input logic a, input string tag);
        int e = edge_n;
        int ec = 0;
        int eb = 0;
        bit is_act = !r && c && w;
        bit is_pre = !r && c && !w;
        bit is_rw  = r && !c && !a;
        if (is_act) begin
            if (open_b[b])                 ec = 1;
            else if (e - last_act[b] < TRC) ec = 2;
            else if (e - last_any < TRRD)   ec = 3;
        end else if (is_pre && !a) begin
            if (open_b[b] && (e - last_act[b] < TRAS_MIN)) ec = 4;
        end else if (is_rw) begin
            if (!open_b[b])                  ec = 5;
            else if (e - last_act[b] < TRCD) ec = 6;
        end
        if (ec != 0) eb = b;
        else begin
            for (int i = 0; i < 4; i++) begin
                if (ec == 0 && open_b[i] && (e - last_act[i] == TRAS_MAX + 1)) begin
                    ec = 7;
                    eb = i;
                end
            end
        end
        if (is_act && !open_b[b]) begin
            open_b[b] = 1;
            last_act[b] = e;
            last_any = e;
        end else if (is_pre) begin
            if (a) begin
                for (int i = 0; i < 4; i++) open_b[i] = 0;
            end else open_b[b] = 0;
        end
        ras_n = r; cas_n = c; we_n = w; ba = b; a10 = a;
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        check_out(tag, ec, eb);
    endtask

    task automatic act(input logic [1:0] b, input string tag);   step(0, 1, 1, b, 0, tag); endtask
    task automatic pre(input logic [1:0] b, input string tag);   step(0, 1, 0, b, 0, tag); endtask
    task automatic preall(input string tag);                     step(0, 1, 0, 2'd3, 1, tag); endtask
    task automatic rd(input logic [1:0] b, input string tag);    step(1, 0, 1, b, 0, tag); endtask
    task automatic wr(input logic [1:0] b, input string tag);    step(1, 0, 0, b, 0, tag); endtask
    task automatic nop(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1, 1, 1, 2'd0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -1000;
            open_b[i] = 0;
        end
        repeat (3) @(negedge clk);
        check_out("R1 during reset", 0, 0);
        rst_n = 1'b1;
        check_out("R1 after release", 0, 0);
        rd(0, "R8 read idle");            // e0
        edge_n = 0;                        // keep edge numbering relative
        for (int i = 0; i < 4; i++) last_act[i] = -1000;
        act(0, "R2 activate");             // e0
        act(1, "R5 trrd short");           // e1 code3
        rd(0, "R9 trcd short");            // e2 code6
        wr(0, "R9 trcd exact");            // e3 ok
        act(0, "R3 open bank");            // e4 code1
        pre(0, "R6 tras_min short");       // e5 code4
        act(0, "R4 trc short");            // e6 code2
        nop(6, "R12 quiet");               // e7..e12
        pre(0, "R6 tras_min exact");       // e13 ok
        nop(2, "R12 quiet");               // e14..e15
        act(0, "R4 trc exact");            // e16 ok
        step(0, 0, 1, 2'd0, 0, "R13 refresh ignored"); // e17
        act(0, "R13 bank still open");     // e18 code1
        preall("R7 precharge all");        // e19
        rd(1, "R7 bank1 closed");          // e20 code5
        act(2, "R2 open bank2");           // e21
        act(3, "R5 trrd short bank3");     // e22 code3
        act(1, "R5 trrd short bank1");     // e23 code3
        act(0, "R11 trc over trrd");       // e24 code2
        nop(37, "R12 quiet");              // e25..e61
        nop(1, "R10 bank2 over-age");      // e62
        act(3, "R11 command over over-age"); // e63 code1
        nop(1, "R10 bank1 over-age");      // e64
        nop(1, "R10 bank0 over-age");      // e65
        nop(2, "R10 no repeat");           // e66..e67
        preall("R7 close all");            // e68
        step(1, 0, 1, 2'd2, 1, "R13 read a10 high"); // e69
        wr(2, "R13 bank2 still idle");     // e70 code5
        pre(2, "R6 precharge idle bank");  // e71
        act(2, "R6 reactivate");           // e72
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R12 watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule